// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Adder

This block performs the additive operations of a sign-magnitude accumulator machine: add, subtract, increase and decrease. The accumulator is a sign bit plus five 6-bit bytes, a 30-bit unsigned magnitude by default. A caller presents the present accumulator value, an operand that has already been extracted from memory or taken from an instruction's address part, a two-bit operation code and the current overflow toggle. The block returns the new accumulator and the new overflow toggle.

Arithmetic is done on sign and magnitude, not on two's complement. When the signs agree, the magnitudes are added. A carry beyond the top byte is dropped and sets the overflow toggle. When the signs differ, the smaller magnitude is taken from the larger, and the result carries the sign of the larger operand. A zero result always keeps the sign the accumulator had before, so minus zero survives. The overflow toggle is sticky. It is set on overflow and is otherwise returned exactly as it arrived.

A transfer is accepted on a valid/ready handshake. The operands are registered in one cycle and the result is registered in the next. The result is then held until the consumer takes it. Only one operation is in flight at a time.

Top module: `sm_accum_adder`

## Requirements
- R1: With opOp=ADD (code 0) and equal effective signs, resMag is the sum of the magnitudes and resSign is the common sign.
- R2: When the sum of two equal-sign magnitudes does not fit in 30 bits, ovfOut is 1 and resMag holds the low 30 bits of the sum.
- R3: When no overflow occurs, ovfOut equals the ovfIn captured with the operation (a set toggle stays set, a clear one stays clear).
- R4: With differing effective signs, resMag is the larger magnitude minus the smaller one, and resSign is the sign of the operand with the larger magnitude.
- R5: Whenever resMag is zero, resSign equals the accumulator sign presented with the operation, including a minus-zero accumulator.
- R6: inOp=SUB (code 1) gives the same result as ADD with the operand sign inverted.
- R7: inOp=INC (code 2) and inOp=DEC (code 3) use only the low two bytes (bits 11:0) of opndMag as the operand magnitude and ignore bits 29:12; DEC also inverts the operand sign.
- R8: inReady is high only while idle. A transfer accepted at a clock edge makes outValid rise after the second following edge, and inReady stays low until the result is taken.
- R9: After reset, inReady is 1 and outValid is 0.
- R10: While outValid is high and outReady is low, outValid, resSign, resMag and ovfOut hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request carries an operation |
| inReady | output | 1 | Block can accept a request |
| inOp | input | 2 | 0 ADD, 1 SUB, 2 INC, 3 DEC |
| accSign | input | 1 | Accumulator sign (1 = minus) |
| accMag | input | 30 | Accumulator magnitude |
| opndSign | input | 1 | Operand sign (1 = minus) |
| opndMag | input | 30 | Operand magnitude |
| ovfIn | input | 1 | Current overflow toggle |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| resSign | output | 1 | New accumulator sign |
| resMag | output | 30 | New accumulator magnitude |
| ovfOut | output | 1 | New overflow toggle |

## Verification
The bound checker watches the timing on every cycle: the handshake latency, the mutual exclusion of inReady and outValid, and the stability of a result held under back-pressure. It also checks two data properties that need no arithmetic model. A toggle captured as set is never returned clear, and a zero magnitude always carries the captured accumulator sign. The values of sums, differences, wraparound, operand inversion for subtract and the masking to the address bytes can only be shown by the bench's scenarios. The bench checks these against a signed-integer model on chosen corner vectors, including minus-zero and exact-wrap cases, and on random vectors.

// File: rtl/sm_acc_pkg.sv
package sm_acc_pkg;
  localparam int BYTE_W     = 6;
  localparam int NUM_BYTES  = 5;
  localparam int ADDR_BYTES = 2;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_INC = 2'd2,
    OP_DEC = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2
  } state_e;

  typedef struct packed {
    logic loadOperands;
    logic loadResult;
  } strobes_t;
endpackage

// File: rtl/sm_acc_ctrl.sv
module sm_acc_ctrl
  import sm_acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output strobes_t strobes
);
  state_e state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (inValid) begin
        strobes.loadOperands = 1'b1;
        stateNext            = ST_CALC;
      end
      ST_CALC: begin
        strobes.loadResult = 1'b1;
        stateNext          = ST_HOLD;
      end
      ST_HOLD: if (outReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_HOLD);
endmodule

// File: rtl/sm_acc_core.sv
module sm_acc_core #(
  parameter int MAG_W = 30
) (
  input  logic             aSign,
  input  logic [MAG_W-1:0] aMag,
  input  logic             bSign,
  input  logic [MAG_W-1:0] bMag,
  input  logic             ovfPrev,
  output logic             sumSign,
  output logic [MAG_W-1:0] sumMag,
  output logic             ovfNext
);
  logic [MAG_W:0]   addExt;
  logic [MAG_W-1:0] diffAB, diffBA, rawMag;
  logic             sameSign, aGeB, rawSign, carry;

  assign sameSign = (aSign == bSign);
  assign addExt   = {1'b0, aMag} + {1'b0, bMag};
  assign diffAB   = aMag - bMag;
  assign diffBA   = bMag - aMag;
  assign aGeB     = (aMag >= bMag);
  assign carry    = addExt[MAG_W];

  always_comb begin
    if (sameSign) begin
      rawMag  = addExt[MAG_W-1:0];
      rawSign = aSign;
    end else if (aGeB) begin
      rawMag  = diffAB;
      rawSign = aSign;
    end else begin
      rawMag  = diffBA;
      rawSign = bSign;
    end
  end

  assign sumMag  = rawMag;
  assign sumSign = (rawMag == '0) ? aSign : rawSign;
  assign ovfNext = ovfPrev | (sameSign & carry);
endmodule

// File: rtl/sm_acc_dp.sv
module sm_acc_dp
  import sm_acc_pkg::*;
#(
  parameter int MAG_W  = 30,
  parameter int ADDR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobes_t         strobes,
  input  logic [1:0]       inOp,
  input  logic             accSign,
  input  logic [MAG_W-1:0] accMag,
  input  logic             opndSign,
  input  logic [MAG_W-1:0] opndMag,
  input  logic             ovfIn,
  output logic             resSign,
  output logic [MAG_W-1:0] resMag,
  output logic             ovfOut
);
  localparam logic [MAG_W-1:0] ADDR_MASK = {{(MAG_W-ADDR_W){1'b0}}, {ADDR_W{1'b1}}};

  op_e              opSel;
  logic             useAddr, invertB;
  logic             effSign;
  logic [MAG_W-1:0] effMag;

  logic             aSignQ, bSignQ, ovfQ;
  logic [MAG_W-1:0] aMagQ, bMagQ;

  logic             sumSign, ovfNext;
  logic [MAG_W-1:0] sumMag;

  assign opSel   = op_e'(inOp);
  assign useAddr = (opSel == OP_INC) || (opSel == OP_DEC);
  assign invertB = (opSel == OP_SUB) || (opSel == OP_DEC);
  assign effSign = opndSign ^ invertB;
  assign effMag  = useAddr ? (opndMag & ADDR_MASK) : opndMag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aSignQ <= 1'b0;
      bSignQ <= 1'b0;
      ovfQ   <= 1'b0;
      aMagQ  <= '0;
      bMagQ  <= '0;
    end else if (strobes.loadOperands) begin
      aSignQ <= accSign;
      bSignQ <= effSign;
      ovfQ   <= ovfIn;
      aMagQ  <= accMag;
      bMagQ  <= effMag;
    end
  end

  sm_acc_core #(.MAG_W(MAG_W)) u_core (
    .aSign   (aSignQ),
    .aMag    (aMagQ),
    .bSign   (bSignQ),
    .bMag    (bMagQ),
    .ovfPrev (ovfQ),
    .sumSign (sumSign),
    .sumMag  (sumMag),
    .ovfNext (ovfNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resSign <= 1'b0;
      resMag  <= '0;
      ovfOut  <= 1'b0;
    end else if (strobes.loadResult) begin
      resSign <= sumSign;
      resMag  <= sumMag;
      ovfOut  <= ovfNext;
    end
  end
endmodule

// File: rtl/sm_accum_adder.sv
module sm_accum_adder
  import sm_acc_pkg::*;
#(
  parameter int BYTE_BITS  = sm_acc_pkg::BYTE_W,
  parameter int WORD_BYTES = sm_acc_pkg::NUM_BYTES,
  parameter int ADDR_BYTES = sm_acc_pkg::ADDR_BYTES,
  localparam int MAG_W     = BYTE_BITS * WORD_BYTES,
  localparam int ADDR_W    = BYTE_BITS * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inOp,
  input  logic             accSign,
  input  logic [MAG_W-1:0] accMag,
  input  logic             opndSign,
  input  logic [MAG_W-1:0] opndMag,
  input  logic             ovfIn,
  output logic             outValid,
  input  logic             outReady,
  output logic             resSign,
  output logic [MAG_W-1:0] resMag,
  output logic             ovfOut
);
  strobes_t strobes;

  sm_acc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  sm_acc_dp #(.MAG_W(MAG_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .inOp     (inOp),
    .accSign  (accSign),
    .accMag   (accMag),
    .opndSign (opndSign),
    .opndMag  (opndMag),
    .ovfIn    (ovfIn),
    .resSign  (resSign),
    .resMag   (resMag),
    .ovfOut   (ovfOut)
  );
endmodule

// File: rtl/sm_accum_adder_chk.sv
module sm_accum_adder_chk #(
  parameter int MAG_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             inReady,
  input logic             accSign,
  input logic             ovfIn,
  input logic             outValid,
  input logic             outReady,
  input logic             resSign,
  input logic [MAG_W-1:0] resMag,
  input logic             ovfOut
);
  logic capOvf, capSign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capOvf  <= 1'b0;
      capSign <= 1'b0;
    end else if (inValid && inReady) begin
      capOvf  <= ovfIn;
      capSign <= accSign;
    end
  end

  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> (!inReady && !outValid) ##1 outValid);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=>
      (outValid && $stable(resMag) && $stable(resSign) && $stable(ovfOut)));

  assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && capOvf) |-> ovfOut);

  assert_zero_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && (resMag == '0)) |-> (resSign == capSign));
endmodule

bind sm_accum_adder sm_accum_adder_chk #(.MAG_W(MAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .accSign  (accSign),
  .ovfIn    (ovfIn),
  .outValid (outValid),
  .outReady (outReady),
  .resSign  (resSign),
  .resMag   (resMag),
  .ovfOut   (ovfOut)
);

// File: tb/sim_sm_accum_adder.sv
module sim_sm_accum_adder;
  localparam int MW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [1:0]    inOp = 2'd0;
  logic          accSign = 1'b0;
  logic [MW-1:0] accMag = '0;
  logic          opndSign = 1'b0;
  logic [MW-1:0] opndMag = '0;
  logic          ovfIn = 1'b0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic          resSign;
  logic [MW-1:0] resMag;
  logic          ovfOut;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int lastAccept = 0;
  logic prevOV = 1'b0;
  bit done = 1'b0;

  logic [MW+1:0] expQ[$];
  string         tagQ[$];

  always #10 clk = ~clk;

  sm_accum_adder u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .accSign(accSign), .accMag(accMag),
    .opndSign(opndSign), .opndMag(opndMag), .ovfIn(ovfIn),
    .outValid(outValid), .outReady(outReady),
    .resSign(resSign), .resMag(resMag), .ovfOut(ovfOut)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (inValid && inReady) lastAccept <= cyc;
  end

  // signed-integer reference: returns {sign, ovf, mag}
  function automatic logic [MW+1:0] model(input logic [1:0] op, input logic aS,
      input logic [MW-1:0] aM, input logic oS, input logic [MW-1:0] oM, input logic ov);
    longint va, vb, s, m, wrapAt;
    logic bS, o, sg;
    logic [MW-1:0] bM;
    wrapAt = longint'(1) << MW;
    bS = oS ^ ((op == 2'd1) || (op == 2'd3));
    bM = (op >= 2'd2) ? (oM & 30'h0000_0FFF) : oM;
    va = aS ? -longint'(aM) : longint'(aM);
    vb = bS ? -longint'(bM) : longint'(bM);
    s  = va + vb;
    m  = (s < 0) ? -s : s;
    o  = ov;
    if (m >= wrapAt) begin
      o = 1'b1;
      m = m - wrapAt;
    end
    sg = (m == 0) ? aS : (s < 0);
    return {sg, o, m[MW-1:0]};
  endfunction

  task automatic check(input string req, input logic [MW+1:0] act, input logic [MW+1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got sign=%0b ovf=%0b mag=%0d, expected sign=%0b ovf=%0b mag=%0d",
               req, act[MW+1], act[MW], act[MW-1:0], exp[MW+1], exp[MW], exp[MW-1:0]);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic aS, input logic [MW-1:0] aM,
      input logic oS, input logic [MW-1:0] oM, input logic ov, input string tag);
    expQ.push_back(model(op, aS, aM, oS, oM, ov));
    tagQ.push_back(tag);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inOp = op; accSign = aS; accMag = aM; opndSign = oS; opndMag = oM; ovfIn = ov;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    opndMag = '1;
  endtask

  // monitor: compare on each new result
  always @(negedge clk) begin
    if (outValid && !prevOV) begin
      string t;
      logic [MW+1:0] e;
      if (expQ.size() == 0) begin
        check("R8 unexpected result", {resSign, ovfOut, resMag}, '0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {resSign, ovfOut, resMag}, e);
        check("R8 latency", (MW+2)'(cyc - lastAccept), (MW+2)'(2));
      end
    end
    prevOV <= outValid;
  end

  task automatic drain();
    while (expQ.size() != 0 || outValid) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    logic [MW+1:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset inReady", (MW+2)'(inReady), (MW+2)'(1));
    check("R9 reset outValid", (MW+2)'(outValid), (MW+2)'(0));
    rst_n = 1'b1;
    @(negedge clk);

    send(2'd0, 0, 30'd5, 0, 30'd7, 0, "R1 plus add");
    send(2'd0, 1, 30'd100, 1, 30'd28, 0, "R1 minus add");
    send(2'd0, 0, 30'h3FFF_FFFF, 0, 30'd1, 0, "R2 R5 exact wrap");
    send(2'd0, 1, 30'h3FFF_FFF6, 1, 30'd20, 0, "R2 wrap minus");
    send(2'd0, 0, 30'd10, 1, 30'd3, 1, "R3 set toggle kept");
    send(2'd0, 0, 30'd10, 0, 30'd3, 0, "R3 clear toggle kept");
    send(2'd0, 0, 30'd3, 1, 30'd10, 0, "R4 larger operand sign");
    send(2'd0, 1, 30'd9, 0, 30'd4, 0, "R4 larger acc sign");
    send(2'd0, 1, 30'd50, 0, 30'd50, 0, "R5 cancel keeps minus");
    send(2'd0, 1, 30'd0, 0, 30'd0, 0, "R5 minus zero");
    send(2'd1, 0, 30'd20, 0, 30'd30, 0, "R6 sub");
    send(2'd1, 1, 30'd5, 1, 30'd5, 0, "R6 R5 sub to minus zero");
    send(2'd1, 0, 30'h3FFF_FFFF, 1, 30'd2, 0, "R6 R2 sub overflow");
    send(2'd2, 0, 30'd100, 0, 30'h3FFF_F001, 0, "R7 inc masks high bytes");
    send(2'd3, 0, 30'd5, 0, 30'h2AAA_AFFF, 0, "R7 dec masks high bytes");
    send(2'd2, 1, 30'd4095, 0, 30'h0000_0FFF, 1, "R7 inc to zero keeps sign");
    drain();

    // R10 / R8 back-pressure
    outReady = 1'b0;
    send(2'd0, 0, 30'd123, 1, 30'd23, 0, "R10 stalled result");
    while (!outValid) @(negedge clk);
    held = {resSign, ovfOut, resMag};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 held valid", (MW+2)'(outValid), (MW+2)'(1));
      check("R10 held data", {resSign, ovfOut, resMag}, held);
      check("R8 not ready while held", (MW+2)'(inReady), (MW+2)'(0));
    end
    outReady = 1'b1;
    drain();

    for (int n = 0; n < 40; n++) begin
      logic [1:0] op;
      logic [MW-1:0] a, b;
      op = 2'($urandom % 4);
      a = (n % 3 == 0) ? 30'($urandom) | 30'h3C00_0000 : 30'($urandom % 5000);
      b = (n % 2 == 0) ? 30'($urandom) : 30'($urandom % 5000);
      send(op, 1'($urandom), a, 1'($urandom), b, 1'($urandom), "R1 R4 R6 R7 random");
    end
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule